// File: doc/BRIEF.md
# Packetised JTAG Bit-Bang Engine

This block executes raw JTAG bit sequences handed to it by a host across a narrow word-write port. The host loads a bit count, the TMS and TDI vectors as packed 32-bit words, a TCK half-period in system clocks, a TDO sample delay and a chain-select mask, then writes a start command. The engine walks the bits out on TCK, TMS and TDI, one TCK period per bit. After every TCK falling edge it samples TDO a programmed number of system clocks later and packs the captured bits into 32-bit words that the host reads back.

One burst holds up to WORDS x 32 bits (1856 with the default of 58 words). Burst length is free from one command to the next, so single bits, bytes, long 896-bit shifts and odd lengths all go through the same path. The TCK rate has no lower limit: the half-period counter runs from 2 system clocks up to the full width of the divider register.

Write map: address bits [7:6] select a region. Region 0 holds the registers at offset 0 (start, bit 0 of the data), 1 (bit count), 2 (half-period), 3 (sample delay) and 4 (chain mask). Region 1 holds TMS word n at offset n, and region 2 holds TDI word n at offset n. The TDO words are read combinationally through `rd_addr_i`.

Top module: `jtag_burst_engine`

## Requirements
- R1: One accepted start produces exactly N TCK rising edges, where N is the bit count. A start with a bit count of zero is ignored.
- R2: Bit j of a burst is driven on TMS and TDI from bit j%32 of word j/32 (LSB first). The pins change only with a TCK fall (or at burst start, with TCK low) and hold steady across the next rising edge.
- R3: TCK idles low. Each TCK high and low phase lasts max(divider, 2) system clocks.
- R4: TDO for bit j is sampled d system clocks after the TCK fall that ends bit j. d is the delay register, with 0 read as 1, and is capped at half-period minus 1.
- R5: Captured bit j lands in bit j%32 of read word j/32. Bits above the last captured bit in the final word read as zero.
- R6: busy_o rises the cycle after an accepted start and falls when the last TDO bit is captured. done_o is a one-cycle pulse in that same cycle.
- R7: A start written while busy_o is high has no effect: the running burst keeps its length and only one done pulse appears.
- R8: TCK, TMS, TDI and output-enable are held low on every chain whose mask bit is clear. TDO is taken only from enabled chains. A start with an all-zero mask is ignored.
- R9: A bit count above WORDS x 32 is treated as WORDS x 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address (region in [7:6], offset in [5:0]) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 6 | TDO word read index |
| rd_data_o | output | 32 | Captured TDO word |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at end of burst |
| chain_tck_o | output | CHAINS | TCK per chain |
| chain_tms_o | output | CHAINS | TMS per chain |
| chain_tdi_o | output | CHAINS | TDI per chain |
| chain_oe_o | output | CHAINS | Output enable per chain |
| chain_tdo_i | input | CHAINS | TDO per chain |

## Verification
The assertions assume that the host leaves the count, half-period, delay, mask and vector words alone while busy_o is high. They also assume that the half-period is not changed mid-burst, since the phase counter is checked against the live value. The bench writes all of its configuration before each start and waits for done_o before it touches anything again. The one exception is the deliberate second start in the busy test. A bench-side TDO model switches TDO at the TCK fall and again a chosen number of cycles later, so the sample point can be located on either side of that change.

// File: rtl/jtb_pkg.sv
package jtb_pkg;
  localparam int WORD_W = 32;
  localparam int WSEL_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} seq_state_e;

  localparam logic [1:0] RG_CTRL = 2'b00;
  localparam logic [1:0] RG_TMS  = 2'b01;
  localparam logic [1:0] RG_TDI  = 2'b10;

  localparam logic [2:0] REG_START = 3'd0;
  localparam logic [2:0] REG_COUNT = 3'd1;
  localparam logic [2:0] REG_DIV   = 3'd2;
  localparam logic [2:0] REG_DLY   = 3'd3;
  localparam logic [2:0] REG_MASK  = 3'd4;
endpackage

// File: rtl/jtb_cfg.sv
module jtb_cfg
  import jtb_pkg::*;
#(
  parameter int WORDS     = 58,
  parameter int CHAINS    = 4,
  parameter int DIV_W     = 16,
  parameter int CNT_REG_W = 16,
  parameter int BIT_W     = 11,
  parameter int WIDX_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [WIDX_W+1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [BIT_W-1:0]    fetch_idx_i,
  output logic                start_o,
  output logic [BIT_W-1:0]    count_o,
  output logic [DIV_W-1:0]    div_o,
  output logic [DIV_W-1:0]    dly_o,
  output logic [CHAINS-1:0]   mask_o,
  output logic                tms_bit_o,
  output logic                tdi_bit_o
);
  localparam int MAX_BITS = WORDS * WORD_W;
  localparam int FW_W     = BIT_W - WSEL_W;

  logic [CNT_REG_W-1:0] count_q;
  logic [DIV_W-1:0]     div_q, dly_q, dly_min;
  logic [CHAINS-1:0]    mask_q;
  logic [WORD_W-1:0]    tms_mem [WORDS];
  logic [WORD_W-1:0]    tdi_mem [WORDS];

  logic [1:0]        region;
  logic [WIDX_W-1:0] widx;
  logic              reg_we, widx_ok;
  logic [FW_W-1:0]   fword;
  logic [WSEL_W-1:0] fbit;

  assign region  = wr_addr_i[WIDX_W+1:WIDX_W];
  assign widx    = wr_addr_i[WIDX_W-1:0];
  assign reg_we  = wr_en_i && (region == RG_CTRL);
  assign widx_ok = int'(widx) < WORDS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      div_q   <= DIV_W'(2);
      dly_q   <= DIV_W'(1);
      mask_q  <= '0;
    end else if (reg_we) begin
      case (widx[2:0])
        REG_COUNT: count_q <= wr_data_i[CNT_REG_W-1:0];
        REG_DIV:   div_q   <= wr_data_i[DIV_W-1:0];
        REG_DLY:   dly_q   <= wr_data_i[DIV_W-1:0];
        REG_MASK:  mask_q  <= wr_data_i[CHAINS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) begin
        tms_mem[i] <= '0;
        tdi_mem[i] <= '0;
      end
    end else if (wr_en_i && widx_ok) begin
      if (region == RG_TMS) tms_mem[widx] <= wr_data_i;
      if (region == RG_TDI) tdi_mem[widx] <= wr_data_i;
    end
  end

  assign start_o = reg_we && (widx[2:0] == REG_START) && wr_data_i[0];

  // clamps applied at use so the host sees raw writes take effect consistently
  assign count_o = (int'(count_q) > MAX_BITS) ? BIT_W'(MAX_BITS) : count_q[BIT_W-1:0];
  assign div_o   = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;
  assign dly_min = (dly_q == '0) ? DIV_W'(1) : dly_q;
  assign dly_o   = (dly_min >= div_o) ? div_o - DIV_W'(1) : dly_min;
  assign mask_o  = mask_q;

  assign fword = fetch_idx_i[BIT_W-1:WSEL_W];
  assign fbit  = fetch_idx_i[WSEL_W-1:0];

  always_comb begin
    tms_bit_o = 1'b0;
    tdi_bit_o = 1'b0;
    if (int'(fword) < WORDS) begin
      tms_bit_o = tms_mem[fword][fbit];
      tdi_bit_o = tdi_mem[fword][fbit];
    end
  end

  p_delay_clamped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_o != '0) && (dly_o < div_o));
  p_count_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= MAX_BITS);
endmodule

// File: rtl/jtb_seq.sv
module jtb_seq
  import jtb_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int BIT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIT_W-1:0] count_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] dly_i,
  input  logic             mask_any_i,
  input  logic             tms_bit_i,
  input  logic             tdi_bit_i,
  output logic [BIT_W-1:0] fetch_idx_o,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             clear_o,
  output logic             sample_o,
  output logic [BIT_W-1:0] samp_idx_o,
  output logic             samp_last_o
);
  seq_state_e       state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_idx_q, samp_idx_q, next_idx;
  logic             tck_q, tms_q, tdi_q, busy_q, done_q, pend_q;
  logic             go, cnt_last, samp_hit, samp_last, tail, next_valid;

  assign go         = start_i && !busy_q && (count_i != '0) && mask_any_i;
  assign cnt_last   = cnt_q == div_i - DIV_W'(1);
  assign samp_hit   = (state_q == ST_LOW) && pend_q && (cnt_q == dly_i - DIV_W'(1));
  assign samp_last  = samp_idx_q == count_i - BIT_W'(1);
  assign tail       = bit_idx_q == count_i;
  assign next_idx   = bit_idx_q + BIT_W'(1);
  assign next_valid = next_idx < count_i;
  assign fetch_idx_o = (state_q == ST_IDLE) ? '0 : next_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bit_idx_q  <= '0;
      samp_idx_q <= '0;
      tck_q      <= 1'b0;
      tms_q      <= 1'b0;
      tdi_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q   <= ST_LOW;
            cnt_q     <= '0;
            bit_idx_q <= '0;
            pend_q    <= 1'b0;
            tms_q     <= tms_bit_i;
            tdi_q     <= tdi_bit_i;
            busy_q    <= 1'b1;
          end
        end
        ST_LOW: begin
          cnt_q <= cnt_q + DIV_W'(1);
          if (samp_hit) pend_q <= 1'b0;
          if (samp_hit && samp_last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            tms_q   <= 1'b0;
            tdi_q   <= 1'b0;
          end else if (cnt_last && !tail) begin
            state_q <= ST_HIGH;
            tck_q   <= 1'b1;
            cnt_q   <= '0;
          end
        end
        ST_HIGH: begin
          cnt_q <= cnt_q + DIV_W'(1);
          if (cnt_last) begin
            state_q    <= ST_LOW;
            tck_q      <= 1'b0;
            cnt_q      <= '0;
            pend_q     <= 1'b1;
            samp_idx_q <= bit_idx_q;
            bit_idx_q  <= next_idx;
            tms_q      <= next_valid ? tms_bit_i : 1'b0;
            tdi_q      <= next_valid ? tdi_bit_i : 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tck_o       = tck_q;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign clear_o     = go;
  assign sample_o    = samp_hit;
  assign samp_idx_o  = samp_idx_q;
  assign samp_last_o = samp_last;

  p_tck_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !tck_q);
  p_phase_in_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < div_i));
  p_pins_move_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && (tms_q != $past(tms_q) || tdi_q != $past(tdi_q)))
      |-> $fell(tck_q));
  p_sample_while_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_hit |-> !tck_q);
  p_idx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_idx_q <= count_i));
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_busy_ends_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  p_start_ignored_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !tail) |=> busy_q);
endmodule

// File: rtl/jtb_capture.sv
module jtb_capture
  import jtb_pkg::*;
#(
  parameter int WORDS  = 58,
  parameter int BIT_W  = 11,
  parameter int WIDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [BIT_W-1:0]  idx_i,
  input  logic              last_i,
  input  logic              tdo_i,
  input  logic [WIDX_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int FW_W = BIT_W - WSEL_W;

  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic [WORD_W-1:0] tdo_mem [WORDS];
  logic [FW_W-1:0]   word;
  logic [WSEL_W-1:0] pos;
  logic              flush;

  assign word    = idx_i[BIT_W-1:WSEL_W];
  assign pos     = idx_i[WSEL_W-1:0];
  assign acc_nxt = acc_q | (WORD_W'(tdo_i) << pos);
  assign flush   = (pos == '1) || last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (sample_i) begin
      acc_q <= flush ? '0 : acc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) tdo_mem[i] <= '0;
    end else if (sample_i && flush && (int'(word) < WORDS)) begin
      tdo_mem[word] <= acc_nxt;
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < WORDS) ? tdo_mem[rd_addr_i] : '0;

  p_word_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (int'(word) < WORDS));
  p_acc_empty_after_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && flush) |=> (acc_q == '0));
endmodule

// File: rtl/jtag_burst_engine.sv
module jtag_burst_engine
  import jtb_pkg::*;
#(
  parameter int WORDS  = 58,
  parameter int CHAINS = 4,
  parameter int DIV_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [$clog2(WORDS)+1:0]      wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic [$clog2(WORDS)-1:0]      rd_addr_i,
  output logic [31:0]                   rd_data_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [CHAINS-1:0]             chain_tck_o,
  output logic [CHAINS-1:0]             chain_tms_o,
  output logic [CHAINS-1:0]             chain_tdi_o,
  output logic [CHAINS-1:0]             chain_oe_o,
  input  logic [CHAINS-1:0]             chain_tdo_i
);
  localparam int WIDX_W    = $clog2(WORDS);
  localparam int MAX_BITS  = WORDS * WORD_W;
  localparam int BIT_W     = $clog2(MAX_BITS + 1);
  localparam int CNT_REG_W = 16;

  logic [BIT_W-1:0]  count, fetch_idx, samp_idx;
  logic [DIV_W-1:0]  div, dly;
  logic [CHAINS-1:0] mask;
  logic start, tms_bit, tdi_bit;
  logic tck, tms, tdi, clear, sample, samp_last, tdo;

  jtb_cfg #(
    .WORDS(WORDS), .CHAINS(CHAINS), .DIV_W(DIV_W),
    .CNT_REG_W(CNT_REG_W), .BIT_W(BIT_W), .WIDX_W(WIDX_W)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fetch_idx_i(fetch_idx),
    .start_o(start), .count_o(count), .div_o(div), .dly_o(dly),
    .mask_o(mask), .tms_bit_o(tms_bit), .tdi_bit_o(tdi_bit)
  );

  jtb_seq #(.DIV_W(DIV_W), .BIT_W(BIT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .count_i(count), .div_i(div), .dly_i(dly),
    .mask_any_i(|mask), .tms_bit_i(tms_bit), .tdi_bit_i(tdi_bit),
    .fetch_idx_o(fetch_idx), .tck_o(tck), .tms_o(tms), .tdi_o(tdi),
    .busy_o, .done_o, .clear_o(clear), .sample_o(sample),
    .samp_idx_o(samp_idx), .samp_last_o(samp_last)
  );

  assign tdo = |(chain_tdo_i & mask);

  jtb_capture #(.WORDS(WORDS), .BIT_W(BIT_W), .WIDX_W(WIDX_W)) u_cap (
    .clk_i, .rst_ni,
    .clear_i(clear), .sample_i(sample), .idx_i(samp_idx), .last_i(samp_last),
    .tdo_i(tdo), .rd_addr_i, .rd_data_o
  );

  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    assign chain_tck_o[c] = tck & mask[c];
    assign chain_tms_o[c] = tms & mask[c];
    assign chain_tdi_o[c] = tdi & mask[c];
    assign chain_oe_o[c]  = mask[c];
  end

  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chain_tck_o | chain_tms_o | chain_tdi_o) & ~chain_oe_o) == '0);
endmodule

// File: tb/jtag_burst_engine_tb.sv
module jtag_burst_engine_tb;
  localparam int CH   = 4;
  localparam int MAXB = 1856;
  localparam int RM   = 8191;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [5:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic busy_o, done_o;
  logic [CH-1:0] chain_tck_o, chain_tms_o, chain_tdi_o, chain_oe_o, chain_tdo_i;

  always #2 clk = ~clk;

  jtag_burst_engine u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o, .busy_o, .done_o, .chain_tck_o, .chain_tms_o, .chain_tdi_o,
    .chain_oe_o, .chain_tdo_i
  );

  int checks = 0, fails = 0;
  logic [CH-1:0] tb_mask = '0;
  int k_sel = 0;

  // monitor / TDO model state (driven only here)
  logic tdo_val = 1'b0;
  logic prev_tck = 1'b0;
  int age = 0, rise_cnt = 0, fall_cnt = 0, done_cnt = 0, dis_hits = 0;
  int hi_run = 0, last_hi = 0;
  logic rec_tms [0:RM];
  logic rec_tdi [0:RM];

  assign chain_tdo_i = ({CH{tdo_val}} & tb_mask) | ~tb_mask;

  function automatic logic pat(int i);
    return 1'(((i ^ (i >> 2) ^ (i >> 5)) & 1));
  endfunction
  function automatic logic [31:0] vtms(int w);
    return 32'h9E37_79B9 * 32'(w + 1);
  endfunction
  function automatic logic [31:0] vtdi(int w);
    return 32'hC2B2_AE35 ^ (32'(w) * 32'h0101_0101);
  endfunction

  always @(negedge clk) begin
    logic t;
    t = |chain_tck_o;
    if (done_o) done_cnt++;
    if (((chain_tck_o | chain_tms_o | chain_tdi_o | chain_oe_o) & ~tb_mask) != '0) dis_hits++;
    if (t) hi_run++;
    if (t && !prev_tck) begin
      rec_tms[rise_cnt & RM] = |chain_tms_o;
      rec_tdi[rise_cnt & RM] = |chain_tdi_o;
      rise_cnt++;
    end
    if (!t && prev_tck) begin
      last_hi = hi_run;
      hi_run = 0;
      tdo_val = pat(fall_cnt);
      fall_cnt++;
      age = 0;
    end else begin
      age++;
      if (k_sel != 0 && age == k_sel) tdo_val = ~tdo_val;
    end
    prev_tck = t;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 40000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  // full burst with all result checks
  task automatic burst(int n, int dv, int dl, logic [CH-1:0] m, int k, string tag);
    int ne, de, le, nw, rb, fb, dc, bad, badw, first;
    logic [31:0] ew;
    ne = (n > MAXB) ? MAXB : n;
    de = (dv < 2) ? 2 : dv;
    le = (dl == 0) ? 1 : dl;
    if (le > de - 1) le = de - 1;
    nw = (ne + 31) / 32;
    @(negedge clk);
    tb_mask = m; k_sel = k;
    wr(8'h01, 32'(n)); wr(8'h02, 32'(dv)); wr(8'h03, 32'(dl)); wr(8'h04, 32'(m));
    for (int w = 0; w < nw; w++) begin
      wr(8'h40 | 8'(w), vtms(w));
      wr(8'h80 | 8'(w), vtdi(w));
    end
    rb = rise_cnt; fb = fall_cnt; dc = done_cnt;
    wr(8'h00, 32'h1);
    chk(busy_o == 1'b1, "R6", {tag, " busy after start"}, int'(busy_o), 1);
    wait_done();
    chk(rise_cnt - rb == ne, "R1", {tag, " tck rises"}, rise_cnt - rb, ne);
    chk(last_hi == de, "R3", {tag, " high phase"}, last_hi, de);
    chk(done_cnt - dc == 1 && !busy_o, "R6", {tag, " done pulses"}, done_cnt - dc, 1);
    bad = 0; first = -1;
    for (int j = 0; j < ne; j++) begin
      if (rec_tms[(rb + j) & RM] !== vtms(j / 32)[j % 32] ||
          rec_tdi[(rb + j) & RM] !== vtdi(j / 32)[j % 32]) begin
        bad++; if (first < 0) first = j;
      end
    end
    chk(bad == 0, "R2", {tag, " tms/tdi mismatches (first bit)"}, first, -1);
    badw = 0; first = -1;
    for (int w = 0; w < nw; w++) begin
      ew = '0;
      for (int b = 0; b < 32; b++) begin
        int j = w * 32 + b;
        if (j < ne) ew[b] = (k != 0 && le > k) ? ~pat(fb + j) : pat(fb + j);
      end
      rd_addr_i = 6'(w);
      #1;
      if (rd_data_o !== ew) begin
        badw++;
        if (first < 0) begin
          first = w;
          $display("FAIL R5 %s word %0d actual=%h expected=%h", tag, w, rd_data_o, ew);
        end
      end
    end
    chk(badw == 0, "R4/R5", {tag, " tdo word mismatches"}, badw, 0);
  endtask

  task automatic t_reset();
    rd_addr_i = '0; #1;
    chk(!busy_o && !done_o, "R6", "reset busy/done", int'(busy_o), 0);
    chk(chain_tck_o == '0 && chain_oe_o == '0, "R3", "reset tck/oe", int'(chain_tck_o), 0);
    chk(rd_data_o == '0, "R5", "reset tdo word", int'(rd_data_o), 0);
  endtask

  task automatic t_lengths();
    burst(1, 2, 1, 4'b0001, 0, "R1 single");
    burst(8, 3, 1, 4'b0001, 0, "R1 byte");
    burst(896, 2, 1, 4'b0001, 0, "R1 long");
    burst(46, 2, 1, 4'b0001, 0, "R5 partial word");
    burst(87, 5, 2, 4'b0011, 0, "R2 odd87");
    burst(199, 2, 1, 4'b1000, 0, "R2 odd199");
  endtask

  task automatic t_delay();
    burst(46, 6, 1, 4'b0001, 1, "R4 d1k1");
    burst(46, 6, 3, 4'b0001, 2, "R4 d3k2");
    burst(46, 6, 0, 4'b0001, 1, "R4 d0clamp");
    burst(33, 4, 200, 4'b0001, 2, "R4 dcap");
    burst(20, 1, 1, 4'b0001, 0, "R3 divmin");
  endtask

  task automatic t_busy_start();
    int rb, dc;
    @(negedge clk);
    tb_mask = 4'b0001; k_sel = 0;
    wr(8'h01, 32'd40); wr(8'h02, 32'd4); wr(8'h03, 32'd1); wr(8'h04, 32'h1);
    rb = rise_cnt; dc = done_cnt;
    wr(8'h00, 32'h1);
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h1);
    wait_done();
    repeat (40) @(negedge clk);
    chk(rise_cnt - rb == 40, "R7", "rises with restart", rise_cnt - rb, 40);
    chk(done_cnt - dc == 1, "R7", "done pulses with restart", done_cnt - dc, 1);
  endtask

  task automatic t_ignored();
    int rb;
    @(negedge clk);
    rb = rise_cnt;
    wr(8'h01, 32'd0); wr(8'h04, 32'h1);
    wr(8'h00, 32'h1);
    chk(!busy_o, "R1", "zero count start", int'(busy_o), 0);
    tb_mask = '0;
    wr(8'h01, 32'd8); wr(8'h04, 32'h0);
    wr(8'h00, 32'h1);
    chk(!busy_o, "R8", "zero mask start", int'(busy_o), 0);
    repeat (30) @(negedge clk);
    chk(rise_cnt == rb && chain_oe_o == '0, "R8", "no tck with zero mask", rise_cnt - rb, 0);
  endtask

  task automatic t_mask();
    int dh;
    dh = dis_hits;
    burst(33, 3, 1, 4'b0100, 0, "R8 one chain");
    chk(dis_hits == dh, "R8", "disabled chain activity", dis_hits - dh, 0);
  endtask

  task automatic t_clamp();
    burst(2000, 2, 1, 4'b0001, 0, "R9 overlong");
  endtask

  task automatic run_all();
    t_reset();
    t_lengths();
    t_delay();
    t_busy_start();
    t_ignored();
    t_mask();
    t_clamp();
  endtask

  initial begin
    bit timed_out = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin repeat (150000) @(negedge clk); timed_out = 1'b1; end
    join_any
    if (timed_out) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule